// File: doc/BRIEF.md
# Two-Antenna Fringe Calibration Correlator

This block measures the interferometric fringe between one pair of antennas so that the array's per-element phase errors can be found. Both real sample streams are taken to complex baseband by a mixer at a quarter of the sample rate. Each antenna's baseband stream is then rotated by its own complex correction coefficient and smoothed by a short moving-sum low-pass filter. The two smoothed streams are combined as one times the conjugate of the other. The products are summed over a programmable number of samples into a complex visibility.

At the end of each integration the visibility is latched onto the output pins and a one-cycle done strobe is raised. Accumulation then restarts from zero on the very next sample, so no sample is lost. Calibration software can read each visibility as a fringe sample, update the coefficients, and see the effect from the following integration on. The sample input is a valid/ready stream that carries one sample from each antenna per transfer. A transfer happens on a rising clock edge where both `in_valid` and `in_ready` are high. `in_ready` is low only while reset is asserted and for the first edge after it. After that it stays high, so the block never applies back-pressure, and idle cycles between transfers are allowed. The coefficients and the integration length are plain control pins.

Top module: `fringe_cal_correlator`

## Requirements
- R1: A sample pair is taken on every rising edge where `in_valid` and `in_ready` are both high. `in_ready` goes high at the first edge after reset and stays high, and idle cycles between transfers change no result.
- R2: The n-th accepted sample of each antenna (n counted from 0 after reset) is multiplied by (−j)^n, which follows the repeating sequence 1, −j, −1, +j.
- R3: Each baseband sample is multiplied by its antenna's complex coefficient, read as signed Q1.15 (real and imaginary parts, 16 bits each). Both parts of the product are shifted arithmetically right by 15 bits, which rounds toward minus infinity.
- R4: Each component of each corrected stream is low-pass filtered as the sum of its last NTAPS values (4 by default). Filter history reads as zero after reset.
- R5: Per filtered sample pair (a, b), the real term is a_re·b_re + a_im·b_im and the imaginary term is a_im·b_re − a_re·b_im.
- R6: An integration spans `int_len` accepted samples, and a value of 0 counts as 1. At its end, `vis_re`/`vis_im` take the sums including the last sample and `vis_done` is high for exactly one cycle. The next sample starts a fresh sum from zero.
- R7: The coefficients and `int_len` are sampled on the first sample of each integration. A change during an integration has no effect until the next one begins.
- R8: The accumulators saturate at +(2^(ACC_W−1)−1) and −2^(ACC_W−1) and never wrap around.
- R9: Reset clears the filters, the accumulators, the sample counter, the mixer phase, the visibility outputs and `vis_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample pair is offered |
| in_ready | output | 1 | The block can take a sample pair |
| ant_a | input | IW | Antenna A sample, signed |
| ant_b | input | IW | Antenna B sample, signed |
| coef_a_re | input | CFW | Antenna A correction, real part, Q1.15 |
| coef_a_im | input | CFW | Antenna A correction, imaginary part, Q1.15 |
| coef_b_re | input | CFW | Antenna B correction, real part, Q1.15 |
| coef_b_im | input | CFW | Antenna B correction, imaginary part, Q1.15 |
| int_len | input | LW | Samples per integration (0 counts as 1) |
| vis_re | output | ACC_W | Latched visibility, real part, signed |
| vis_im | output | ACC_W | Latched visibility, imaginary part, signed |
| vis_done | output | 1 | One-cycle strobe when a visibility is latched |

## Verification
The bench builds the block with 12-bit samples, 16-bit coefficients, four filter taps and an 8-bit length. It narrows the accumulator to 30 bits. With that width, a full-scale tone at a quarter of the sample rate saturates the sum within a few dozen samples. Both the positive and the negative clamp can then be reached with short integrations, instead of the millions of samples a 48-bit sum would need. The 8-bit length keeps every integration short, so length changes made mid-stream, lengths of one and zero, and coefficient changes can all be exercised many times within one run.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  // Phase of the quarter-rate down-conversion mixer
  typedef enum logic [1:0] {
    MIX_POS1 = 2'd0,  // multiply by 1
    MIX_NEGJ = 2'd1,  // multiply by -j
    MIX_NEG1 = 2'd2,  // multiply by -1
    MIX_POSJ = 2'd3   // multiply by +j
  } mix_ph_e;

  function automatic mix_ph_e mix_advance(input mix_ph_e p);
    case (p)
      MIX_POS1: return MIX_NEGJ;
      MIX_NEGJ: return MIX_NEG1;
      MIX_NEG1: return MIX_POSJ;
      default:  return MIX_POS1;
    endcase
  endfunction

endpackage

// File: rtl/fcc_front.sv
// Quarter-rate mixer followed by complex phase correction, one register stage.
module fcc_front
  import fcc_pkg::*;
#(
  parameter int IW  = 12,
  parameter int CFW = 16,
  parameter int CW  = IW + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic signed [IW-1:0]  smp,
  input  logic signed [CFW-1:0] c_re,
  input  logic signed [CFW-1:0] c_im,
  output logic signed [CW-1:0]  o_re,
  output logic signed [CW-1:0]  o_im
);

  localparam int XW   = IW + 1;
  localparam int PW   = XW + CFW;
  localparam int SW   = PW + 1;
  localparam int FRAC = CFW - 1;

  mix_ph_e ph_q;
  logic signed [XW-1:0] xe, bb_re, bb_im;
  logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
  logic signed [SW-1:0] s_re, s_im;

  assign xe = XW'(smp);

  always_comb begin
    bb_re = '0;
    bb_im = '0;
    case (ph_q)
      MIX_POS1: bb_re = xe;
      MIX_NEGJ: bb_im = -xe;
      MIX_NEG1: bb_re = -xe;
      default:  bb_im = xe;
    endcase
  end

  assign p_rr = bb_re * c_re;
  assign p_ii = bb_im * c_im;
  assign p_ri = bb_re * c_im;
  assign p_ir = bb_im * c_re;
  assign s_re = p_rr - p_ii;
  assign s_im = p_ri + p_ir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= MIX_POS1;
      o_re <= '0;
      o_im <= '0;
    end else if (en) begin
      ph_q <= mix_advance(ph_q);
      o_re <= CW'(s_re >>> FRAC);
      o_im <= CW'(s_im >>> FRAC);
    end
  end

  // R2
  mix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (ph_q != $past(ph_q)));

  // R1
  front_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(o_re) && $stable(o_im) && $stable(ph_q)));

endmodule

// File: rtl/fcc_boxcar.sv
// Moving-sum low-pass filter over NTAPS samples.
module fcc_boxcar #(
  parameter int W     = 14,
  parameter int NTAPS = 4,
  parameter int OW    = W + $clog2(NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [W-1:0]  x,
  output logic signed [OW-1:0] y
);

  logic signed [W-1:0] tap_q [NTAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) tap_q[i] <= '0;
    end else if (en) begin
      tap_q[0] <= x;
      for (int i = 1; i < NTAPS; i++) tap_q[i] <= tap_q[i-1];
    end
  end

  always_comb begin
    y = '0;
    for (int i = 0; i < NTAPS; i++) y = y + OW'(tap_q[i]);
  end

  // R4
  box_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(y));

  // R4
  box_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (tap_q[0] == $past(x)));

endmodule

// File: rtl/fcc_xacc.sv
// Conjugate cross product and saturating complex integrator.
module fcc_xacc #(
  parameter int FW    = 16,
  parameter int ACC_W = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    last,
  input  logic signed [FW-1:0]    a_re,
  input  logic signed [FW-1:0]    a_im,
  input  logic signed [FW-1:0]    b_re,
  input  logic signed [FW-1:0]    b_im,
  output logic signed [ACC_W-1:0] vis_re,
  output logic signed [ACC_W-1:0] vis_im,
  output logic                    done
);

  localparam int TW = 2 * FW + 1;
  localparam int EW = ((ACC_W > TW) ? ACC_W : TW) + 1;
  localparam logic signed [EW-1:0] SAT_HI =
    $signed({{(EW-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}});
  localparam logic signed [EW-1:0] SAT_LO =
    $signed({{(EW-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}});

  logic signed [TW-1:0]    t_re, t_im;
  logic signed [ACC_W-1:0] acc_re, acc_im, n_re, n_im;

  function automatic logic signed [ACC_W-1:0] sat_add(
    input logic signed [ACC_W-1:0] s,
    input logic signed [TW-1:0]    t
  );
    logic signed [EW-1:0] w;
    w = EW'(s) + EW'(t);
    if (w > SAT_HI)      w = SAT_HI;
    else if (w < SAT_LO) w = SAT_LO;
    return ACC_W'(w);
  endfunction

  assign t_re = a_re * b_re + a_im * b_im;
  assign t_im = a_im * b_re - a_re * b_im;
  assign n_re = sat_add(acc_re, t_re);
  assign n_im = sat_add(acc_im, t_im);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_re <= '0;
      acc_im <= '0;
      vis_re <= '0;
      vis_im <= '0;
      done   <= 1'b0;
    end else begin
      done <= en && last;
      if (en) begin
        if (last) begin
          vis_re <= n_re;
          vis_im <= n_im;
          acc_re <= '0;
          acc_im <= '0;
        end else begin
          acc_re <= n_re;
          acc_im <= n_im;
        end
      end
    end
  end

  // R6
  acc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (acc_re == '0 && acc_im == '0));

  // R6
  vis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(vis_re) && $stable(vis_im)));

  // R8
  sat_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !last && t_re >= 0) |=> (acc_re >= $past(acc_re)));

  // R8
  sat_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !last && t_re <= 0) |=> (acc_re <= $past(acc_re)));

endmodule

// File: rtl/fringe_cal_correlator.sv
module fringe_cal_correlator
  import fcc_pkg::*;
#(
  parameter int IW    = 12,
  parameter int CFW   = 16,
  parameter int NTAPS = 4,
  parameter int ACC_W = 48,
  parameter int LW    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IW-1:0]    ant_a,
  input  logic signed [IW-1:0]    ant_b,
  input  logic signed [CFW-1:0]   coef_a_re,
  input  logic signed [CFW-1:0]   coef_a_im,
  input  logic signed [CFW-1:0]   coef_b_re,
  input  logic signed [CFW-1:0]   coef_b_im,
  input  logic [LW-1:0]           int_len,
  output logic signed [ACC_W-1:0] vis_re,
  output logic signed [ACC_W-1:0] vis_im,
  output logic                    vis_done
);

  localparam int NANT = 2;
  localparam int CW   = IW + 2;
  localparam int FW   = CW + $clog2(NTAPS);

  logic          rdy_q, accept, start, last_in;
  logic [LW-1:0] cnt_q, len_q, len_fix, len_now;
  logic          v1_q, last1_q, v2_q, last2_q;

  logic signed [CFW-1:0] sh_re_q [NANT];
  logic signed [CFW-1:0] sh_im_q [NANT];
  logic signed [CFW-1:0] port_re [NANT];
  logic signed [CFW-1:0] port_im [NANT];
  logic signed [CFW-1:0] eff_re  [NANT];
  logic signed [CFW-1:0] eff_im  [NANT];
  logic signed [IW-1:0]  smp     [NANT];
  logic signed [CW-1:0]  cor     [2*NANT];
  logic signed [FW-1:0]  flt     [2*NANT];

  assign in_ready = rdy_q;
  assign accept   = in_valid && rdy_q;
  assign start    = (cnt_q == '0);
  assign len_fix  = (int_len == '0) ? LW'(1) : int_len;
  assign len_now  = start ? len_fix : len_q;
  assign last_in  = (cnt_q == len_now - LW'(1));

  assign smp[0]     = ant_a;
  assign smp[1]     = ant_b;
  assign port_re[0] = coef_a_re;
  assign port_im[0] = coef_a_im;
  assign port_re[1] = coef_b_re;
  assign port_im[1] = coef_b_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      cnt_q   <= '0;
      len_q   <= LW'(1);
      v1_q    <= 1'b0;
      last1_q <= 1'b0;
      v2_q    <= 1'b0;
      last2_q <= 1'b0;
      for (int k = 0; k < NANT; k++) begin
        sh_re_q[k] <= '0;
        sh_im_q[k] <= '0;
      end
    end else begin
      rdy_q   <= 1'b1;
      v1_q    <= accept;
      last1_q <= accept && last_in;
      v2_q    <= v1_q;
      last2_q <= v1_q && last1_q;
      if (accept) begin
        cnt_q <= last_in ? '0 : cnt_q + LW'(1);
        if (start) begin
          len_q <= len_fix;
          for (int k = 0; k < NANT; k++) begin
            sh_re_q[k] <= port_re[k];
            sh_im_q[k] <= port_im[k];
          end
        end
      end
    end
  end

  for (genvar k = 0; k < NANT; k++) begin : g_ant
    assign eff_re[k] = start ? port_re[k] : sh_re_q[k];
    assign eff_im[k] = start ? port_im[k] : sh_im_q[k];

    fcc_front #(.IW(IW), .CFW(CFW), .CW(CW)) u_front (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (accept),
      .smp  (smp[k]),
      .c_re (eff_re[k]),
      .c_im (eff_im[k]),
      .o_re (cor[2*k]),
      .o_im (cor[2*k+1])
    );
  end

  for (genvar m = 0; m < 2*NANT; m++) begin : g_lpf
    fcc_boxcar #(.W(CW), .NTAPS(NTAPS), .OW(FW)) u_lpf (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (v1_q),
      .x    (cor[m]),
      .y    (flt[m])
    );
  end

  fcc_xacc #(.FW(FW), .ACC_W(ACC_W)) u_xacc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (v2_q),
    .last  (last2_q),
    .a_re  (flt[0]),
    .a_im  (flt[1]),
    .b_re  (flt[2]),
    .b_im  (flt[3]),
    .vis_re(vis_re),
    .vis_im(vis_im),
    .done  (vis_done)
  );

  // R1
  ready_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> in_ready);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q < len_q));

  // R7
  coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !start) |=> ($stable(sh_re_q[0]) && $stable(sh_im_q[0]) &&
                            $stable(sh_re_q[1]) && $stable(sh_im_q[1]) &&
                            $stable(len_q)));

  // R6
  done_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_done && len_q != LW'(1)) |=> !vis_done);

endmodule

// File: tb/sim_fringe_cal_correlator.sv
module sim_fringe_cal_correlator;

  localparam int CLK_PERIOD = 10;
  localparam int IW = 12, CFW = 16, NTAPS = 4, ACC_W = 30, LW = 8;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic in_ready, vis_done;
  logic signed [IW-1:0]    ant_a = '0, ant_b = '0;
  logic signed [CFW-1:0]   car = '0, cai = '0, cbr = '0, cbi = '0;
  logic [LW-1:0]           int_len = LW'(1);
  logic signed [ACC_W-1:0] vis_re, vis_im;

  int n_tests = 0, n_fail = 0, cycles = 0;
  string cur_req = "R2";

  fringe_cal_correlator #(.IW(IW), .CFW(CFW), .NTAPS(NTAPS), .ACC_W(ACC_W), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ant_a(ant_a), .ant_b(ant_b),
    .coef_a_re(car), .coef_a_im(cai), .coef_b_re(cbr), .coef_b_im(cbi),
    .int_len(int_len), .vis_re(vis_re), .vis_im(vis_im), .vis_done(vis_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  longint exp_re[$], exp_im[$];
  longint m_acc_re = 0, m_acc_im = 0;
  int     m_cnt = 0, m_len = 1, m_ph = 0;
  longint m_c[4];
  longint hist[4][NTAPS];
  longint SAT_HI, SAT_LO;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > SAT_HI) return SAT_HI;
    if (v < SAT_LO) return SAT_LO;
    return v;
  endfunction

  // Drive one sample pair and advance the reference model (R1..R8)
  task automatic put(input int xa, input int xb);
    longint bi[2], bq[2], cr[2], ci[2], f[4], tre, tim, x;
    @(negedge clk);
    in_valid = 1'b1;
    ant_a = IW'(xa);
    ant_b = IW'(xb);
    if (m_cnt == 0) begin
      m_len = (int_len == 0) ? 1 : int'(int_len);
      m_c[0] = car; m_c[1] = cai; m_c[2] = cbr; m_c[3] = cbi;
    end
    for (int k = 0; k < 2; k++) begin
      x = (k == 0) ? longint'(xa) : longint'(xb);
      case (m_ph)
        0: begin bi[k] = x;  bq[k] = 0;  end
        1: begin bi[k] = 0;  bq[k] = -x; end
        2: begin bi[k] = -x; bq[k] = 0;  end
        default: begin bi[k] = 0; bq[k] = x; end
      endcase
      cr[k] = (bi[k] * m_c[2*k] - bq[k] * m_c[2*k+1]) >>> (CFW-1);
      ci[k] = (bi[k] * m_c[2*k+1] + bq[k] * m_c[2*k]) >>> (CFW-1);
    end
    for (int c = 0; c < 4; c++) begin
      for (int t = NTAPS-1; t > 0; t--) hist[c][t] = hist[c][t-1];
      hist[c][0] = (c == 0) ? cr[0] : (c == 1) ? ci[0] : (c == 2) ? cr[1] : ci[1];
      f[c] = 0;
      for (int t = 0; t < NTAPS; t++) f[c] += hist[c][t];
    end
    tre = f[0]*f[2] + f[1]*f[3];
    tim = f[1]*f[2] - f[0]*f[3];
    m_acc_re = sat(m_acc_re + tre);
    m_acc_im = sat(m_acc_im + tim);
    m_ph = (m_ph + 1) % 4;
    m_cnt++;
    if (m_cnt == m_len) begin
      exp_re.push_back(m_acc_re);
      exp_im.push_back(m_acc_im);
      m_acc_re = 0; m_acc_im = 0; m_cnt = 0;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    idle(8);
    check(exp_re.size() == 0, {cur_req, " pending"}, exp_re.size(), 0);
  endtask

  // monitor: compares each latched visibility with the next expected item
  always @(negedge clk) begin
    if (rst_n && vis_done) begin
      if (exp_re.size() == 0) begin
        check(1'b0, "R6 extra done", 1, 0);
      end else begin
        longint er, ei;
        er = exp_re.pop_front();
        ei = exp_im.pop_front();
        check(longint'(vis_re) == er, {cur_req, " re"}, longint'(vis_re), er);
        check(longint'(vis_im) == ei, {cur_req, " im"}, longint'(vis_im), ei);
      end
    end
  end

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "watchdog", cycles, 100000);
      finish_up();
    end
  end

  initial begin
    SAT_HI = (longint'(1) <<< (ACC_W-1)) - 1;
    SAT_LO = -(longint'(1) <<< (ACC_W-1));
    for (int c = 0; c < 4; c++) for (int t = 0; t < NTAPS; t++) hist[c][t] = 0;

    // R9: reset state
    idle(3);
    check(vis_re == 0, "R9 vis_re", vis_re, 0);
    check(vis_im == 0, "R9 vis_im", vis_im, 0);
    check(vis_done == 0, "R9 done", vis_done, 0);
    check(in_ready == 0, "R1 ready in reset", in_ready, 0);
    rst_n = 1'b1;
    idle(2);
    check(in_ready == 1, "R1 ready", in_ready, 1);

    // R2: quarter-rate tone, unity coefficients, continuous
    cur_req = "R2";
    car = 16'sd32767; cai = 0; cbr = 16'sd32767; cbi = 0; int_len = 8;
    for (int i = 0; i < 24; i++) put((i % 4 == 0) ? 1500 : (i % 4 == 2) ? -1500 : 0,
                                     (i % 2 == 0) ? 700 : -300);
    drain();

    // R3: rotating coefficients, random samples
    cur_req = "R3";
    car = 16'sd23170; cai = 16'sd23170; cbr = 16'sd30000; cbi = -16'sd12000; int_len = 5;
    for (int i = 0; i < 20; i++) put($signed($urandom_range(0, 1000)) - 500,
                                     $signed($urandom_range(0, 1000)) - 500);
    drain();

    // R1: idle gaps between transfers change nothing
    cur_req = "R1";
    for (int i = 0; i < 18; i++) begin
      put($signed($urandom_range(0, 800)) - 400, $signed($urandom_range(0, 800)) - 400);
      idle($urandom_range(0, 3));
    end
    drain();

    // R5: asymmetric coefficients expose the conjugate order
    cur_req = "R5";
    car = 16'sd32767; cai = 0; cbr = 0; cbi = 16'sd32767; int_len = 6;
    for (int i = 0; i < 18; i++) put(300 + i * 20, -200 + i * 15);
    drain();

    // R4: short integrations right after a burst of zeros show the filter window
    cur_req = "R4";
    car = 16'sd32767; cai = 0; cbr = 16'sd32767; cbi = 0; int_len = 1;
    for (int i = 0; i < 6; i++) put(0, 0);
    for (int i = 0; i < 6; i++) put(1000, 1000);
    drain();

    // R7: coefficient change in mid-integration waits for the next one
    cur_req = "R7";
    int_len = 6;
    for (int i = 0; i < 3; i++) put(400 - i * 50, 250 + i * 30);
    car = -16'sd20000; cai = 16'sd9000;
    for (int i = 0; i < 9; i++) put(400 - i * 50, 250 + i * 30);
    // R7: length change in mid-integration waits too
    int_len = 4;
    for (int i = 0; i < 3; i++) put(100 * i, -90 * i);
    int_len = 7;
    for (int i = 0; i < 8; i++) put(100 - 20 * i, 60 + 10 * i);
    drain();

    // R6: lengths of one and zero give a visibility per sample
    cur_req = "R6";
    int_len = 0;
    for (int i = 0; i < 5; i++) put(900 - 100 * i, 300 + 50 * i);
    int_len = 1;
    for (int i = 0; i < 5; i++) put(-500 + 100 * i, 200);
    int_len = 3;
    for (int i = 0; i < 9; i++) put(600, -600);
    drain();

    // R8: positive and negative saturation
    cur_req = "R8";
    car = 16'sd32767; cai = 0; cbr = 16'sd32767; cbi = 0; int_len = 40;
    for (int i = 0; i < 40; i++) put((i % 4 == 0) ? 2047 : (i % 4 == 2) ? -2047 : 0,
                                     (i % 4 == 0) ? 2047 : (i % 4 == 2) ? -2047 : 0);
    for (int i = 0; i < 40; i++) put((i % 4 == 0) ? 2047 : (i % 4 == 2) ? -2047 : 0,
                                     (i % 4 == 0) ? -2047 : (i % 4 == 2) ? 2047 : 0);
    drain();

    finish_up();
  end

endmodule